// File: doc/BRIEF.md
# Flash Erase-All Unsecure Sequencer

This block holds the configuration byte of a flash controller and runs the mass-erase-and-unsecure operation that goes with it. Software reads and writes the byte through a simple write-enable register port. Two of its bits enable interrupts, one bit asks for a running sector erase to be suspended, and one bit is a read-only flag that shows an erase-all request is in progress. The remaining low bits read as zero.

A pulse on the external erase-all trigger is accepted only while the command-complete flag is high, which means no command is running. Once it is accepted, the block drives four command strobes to the flash array, one after another: erase every block, check that the array is blank, write the security byte to its open value, and finally open the security field. Each strobe stays high until the array answers with a done pulse. The array also returns a pass bit on its done pulse, and a failed blank check stops the run early. The interrupt output is a level built from the enable bits, the command-complete flag and an incoming read-collision flag.

Top module: `flash_unsecure_seq`

## Requirements
- R1: After reset the register reads 0x00, the command-complete flag `cmd_done` is 1, `sec_open` is 0 and `arr_cmd` is 4'b0000.
- R2: Register bits 7 (command-complete interrupt enable), 6 (read-collision interrupt enable) and 4 (suspend request) take the value written and read it back on the cycle after the write; bit 4 also drives `erase_suspend`.
- R3: Bits 3 to 0 always read 0; a 0 in bit 2 denotes the data-flash/EEPROM configuration.
- R4: Bit 5, the request flag, ignores software writes, both while idle and while a run is in progress.
- R5: A trigger sampled while idle with `cmd_done` high sets bit 5, clears `cmd_done` and raises the erase strobe on the next cycle.
- R6: `arr_cmd` is one-hot or zero, with bit 0 for erase all, bit 1 for blank check, bit 2 for program security byte and bit 3 for open security. The strobes run in the order 0, 1, 2, 3, and each is held until `arr_done`.
- R7: The `arr_done` that ends the open-security step clears bit 5, sets `cmd_done` and sets `sec_open`, all on the same edge.
- R8: If `arr_pass` is 0 on the done of the blank-check step, the run aborts. No program or open strobe follows, `sec_open` keeps its value, bit 5 clears and `cmd_done` sets.
- R9: A trigger that arrives while a run is in progress is ignored and not queued, so no further strobe follows the end of that run.
- R10: `irq` = (bit 7 AND `cmd_done`) OR (bit 6 AND `rd_collision`), as a combinational level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| erase_all_trig | input | 1 | External erase-all request pulse |
| rd_collision | input | 1 | Read-collision error flag |
| arr_cmd | output | 4 | One-hot command strobes to the array |
| arr_done | input | 1 | Array completion pulse for the current strobe |
| arr_pass | input | 1 | Blank-check result, valid with arr_done |
| cmd_done | output | 1 | Command-complete flag |
| sec_open | output | 1 | Security field in the open state |
| erase_suspend | output | 1 | Suspend request to the sector-erase logic |
| irq | output | 1 | Interrupt request level |

## Verification
The bench writes all ones to the register to show that bit 5 does not take a software write, and then clears the register in the middle of a run to show the bit also holds while busy. It fires a second trigger during the erase step; a design that queued that trigger would start a second strobe sequence, and the scoreboard would flag that strobe as unexpected. A failed blank check must end the run after the blank-check strobe, so a design that carried on to program or open security would leave extra strobes and set `sec_open`. The interrupt level is checked for both sources, and also across the drop and return of `cmd_done` during a run.

// File: rtl/fus_pkg.sv
package fus_pkg;
  localparam int REG_W    = 8;
  localparam int BIT_CCIE = 7;
  localparam int BIT_RCIE = 6;
  localparam int BIT_REQ  = 5;
  localparam int BIT_SUSP = 4;
  localparam int CMD_N    = 4;
  localparam int IRQ_N    = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ERASE,
    ST_VERIFY,
    ST_PROG,
    ST_OPEN
  } step_e;
endpackage

// File: rtl/fus_cfg_reg.sv
module fus_cfg_reg
  import fus_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  logic             req_flag,
  output logic [REG_W-1:0] rdata,
  output logic             ccie,
  output logic             rcie,
  output logic             suspend
);
  localparam logic [REG_W-1:0] RW_MASK =
    REG_W'((1 << BIT_CCIE) | (1 << BIT_RCIE) | (1 << BIT_SUSP));

  logic unused_wbits;
  assign unused_wbits = ^(wdata & ~RW_MASK);

  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (RW_MASK[i]) begin : g_rw
      logic q, d;
      always_comb begin
        d = q;
        if (wr_en) d = wdata[i];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= d;
      end
      assign rdata[i] = q;
    end else if (i == BIT_REQ) begin : g_req
      assign rdata[i] = req_flag;
    end else begin : g_zero
      assign rdata[i] = 1'b0;
    end
  end

  assign ccie    = rdata[BIT_CCIE];
  assign rcie    = rdata[BIT_RCIE];
  assign suspend = rdata[BIT_SUSP];

  // R2: a write shows up in the read data on the next cycle
  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rdata[BIT_CCIE] == $past(wdata[BIT_CCIE])) &&
              (rdata[BIT_SUSP] == $past(wdata[BIT_SUSP])));
endmodule

// File: rtl/fus_sequencer.sv
module fus_sequencer
  import fus_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic             arr_done,
  input  logic             arr_pass,
  output logic [CMD_N-1:0] arr_cmd,
  output logic             req_flag,
  output logic             ccif,
  output logic             sec_open
);
  step_e state_q, state_d;
  logic  ccif_q, ccif_d;
  logic  sec_q, sec_d;
  logic  start, finish, abort;

  assign start  = (state_q == ST_IDLE) && ccif_q && trig;
  assign finish = (state_q == ST_OPEN) && arr_done;
  assign abort  = (state_q == ST_VERIFY) && arr_done && !arr_pass;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start) state_d = ST_ERASE;
      ST_ERASE:  if (arr_done) state_d = ST_VERIFY;
      ST_VERIFY: if (arr_done) state_d = arr_pass ? ST_PROG : ST_IDLE;
      ST_PROG:   if (arr_done) state_d = ST_OPEN;
      ST_OPEN:   if (arr_done) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    ccif_d = ccif_q;
    if (start)           ccif_d = 1'b0;
    if (finish || abort) ccif_d = 1'b1;
    sec_d = sec_q;
    if (finish) sec_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ccif_q  <= 1'b1;
      sec_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ccif_q  <= ccif_d;
      sec_q   <= sec_d;
    end
  end

  always_comb begin
    arr_cmd = '0;
    unique case (state_q)
      ST_ERASE:  arr_cmd[0] = 1'b1;
      ST_VERIFY: arr_cmd[1] = 1'b1;
      ST_PROG:   arr_cmd[2] = 1'b1;
      ST_OPEN:   arr_cmd[3] = 1'b1;
      default:   arr_cmd = '0;
    endcase
  end

  assign req_flag = (state_q != ST_IDLE);
  assign ccif     = ccif_q;
  assign sec_open = sec_q;

  assert_cmd_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(arr_cmd));
  assert_prog_after_verify_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arr_cmd[2]) |-> $past(arr_cmd[1] && arr_done && arr_pass));
  assert_busy_clears_ccif_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_flag |-> !ccif);
  assert_start_erase_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_flag && ccif && trig) |=> arr_cmd[0]);
  assert_abort_keeps_sec_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_cmd[1] && arr_done && !arr_pass) |=> (!req_flag && ccif && $stable(sec_open)));
  assert_sec_after_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sec_open) |-> $past(arr_cmd[3] && arr_done));
endmodule

// File: rtl/fus_irq.sv
module fus_irq
  import fus_pkg::*;
(
  input  logic [IRQ_N-1:0] enable,
  input  logic [IRQ_N-1:0] flag,
  output logic             irq
);
  logic [IRQ_N-1:0] hit;
  for (genvar i = 0; i < IRQ_N; i++) begin : g_src
    assign hit[i] = enable[i] & flag[i];
  end
  assign irq = |hit;
endmodule

// File: rtl/flash_unsecure_seq.sv
module flash_unsecure_seq
  import fus_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             erase_all_trig,
  input  logic             rd_collision,
  output logic [CMD_N-1:0] arr_cmd,
  input  logic             arr_done,
  input  logic             arr_pass,
  output logic             cmd_done,
  output logic             sec_open,
  output logic             erase_suspend,
  output logic             irq
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  logic       req_flag, ccie, rcie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  fus_cfg_reg u_cfg (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .wr_en    (reg_wr_en),
    .wdata    (reg_wdata),
    .req_flag (req_flag),
    .rdata    (reg_rdata),
    .ccie     (ccie),
    .rcie     (rcie),
    .suspend  (erase_suspend)
  );

  fus_sequencer u_seq (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .trig     (erase_all_trig),
    .arr_done (arr_done),
    .arr_pass (arr_pass),
    .arr_cmd  (arr_cmd),
    .req_flag (req_flag),
    .ccif     (cmd_done),
    .sec_open (sec_open)
  );

  fus_irq u_irq (
    .enable ({rcie, ccie}),
    .flag   ({rd_collision, cmd_done}),
    .irq    (irq)
  );

  assert_irq_complete_R10: assert property (@(posedge clk) disable iff (!rst_core_n)
    (reg_rdata[BIT_CCIE] && cmd_done) |-> irq);
  assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!reg_rdata[BIT_CCIE] && !reg_rdata[BIT_RCIE]) |-> !irq);
  assert_low_bits_zero_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    reg_rdata[3:0] == 4'b0000);
endmodule

// File: tb/tb_flash_unsecure_seq.sv
`timescale 1ns/1ps
module tb_flash_unsecure_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       erase_all_trig = 1'b0;
  logic       rd_collision = 1'b0;
  logic [3:0] arr_cmd;
  logic       arr_done = 1'b0;
  logic       arr_pass = 1'b0;
  logic       cmd_done, sec_open, erase_suspend, irq;

  int checks = 0;
  int errors = 0;
  logic [3:0] exp_q[$];
  logic [3:0] prev_cmd = 4'b0000;
  int   lat_cnt = 0;
  bit   fail_verify = 1'b0;
  localparam int LAT = 4;

  always #2.5 clk = ~clk;

  flash_unsecure_seq dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .erase_all_trig(erase_all_trig),
    .rd_collision(rd_collision), .arr_cmd(arr_cmd), .arr_done(arr_done),
    .arr_pass(arr_pass), .cmd_done(cmd_done), .sec_open(sec_open),
    .erase_suspend(erase_suspend), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // array model: answers each strobe after LAT cycles
  always @(negedge clk) begin
    if (arr_done) begin
      arr_done <= 1'b0;
      lat_cnt  <= 0;
    end else if (arr_cmd != 4'b0000) begin
      if (lat_cnt == LAT) begin
        arr_done <= 1'b1;
        arr_pass <= !(arr_cmd[1] && fail_verify);
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end
  end

  // monitor: each new strobe is compared against the scoreboard queue (R6, R8, R9)
  always @(negedge clk) begin
    if (arr_cmd != prev_cmd && arr_cmd != 4'b0000) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 unexpected strobe", arr_cmd, 0);
      end else begin
        logic [3:0] e;
        e = exp_q.pop_front();
        chk(arr_cmd == e, "R6 strobe order", arr_cmd, e);
      end
    end
    prev_cmd <= arr_cmd;
  end

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk);
    reg_wr_en = 1'b1;
    reg_wdata = v;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic fire(input bit push_pass, input bit push_fail);
    if (push_pass) begin
      exp_q.push_back(4'b0001); exp_q.push_back(4'b0010);
      exp_q.push_back(4'b0100); exp_q.push_back(4'b1000);
    end
    if (push_fail) begin
      exp_q.push_back(4'b0001); exp_q.push_back(4'b0010);
    end
    @(negedge clk);
    erase_all_trig = 1'b1;
    @(negedge clk);
    erase_all_trig = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200; i++) begin
      if (!reg_rdata[5]) break;
      @(negedge clk);
    end
  endtask

  initial begin
    do_reset();
    chk(reg_rdata == 8'h00, "R1 reset rdata", reg_rdata, 8'h00);
    chk(cmd_done == 1'b1 && sec_open == 1'b0, "R1 reset flags", {cmd_done, sec_open}, 2'b10);
    chk(arr_cmd == 4'b0000, "R1 reset strobes", arr_cmd, 0);

    wr(8'hFF);
    chk(reg_rdata == 8'hD0, "R4 R3 write all ones", reg_rdata, 8'hD0);
    chk(erase_suspend == 1'b1, "R2 suspend out", erase_suspend, 1);
    chk(irq == 1'b1, "R10 irq from complete", irq, 1);
    wr(8'h40);
    chk(reg_rdata == 8'h40 && erase_suspend == 1'b0, "R2 readback 0x40", reg_rdata, 8'h40);
    chk(irq == 1'b0, "R10 no irq without collision", irq, 0);
    @(negedge clk); rd_collision = 1'b1; #0.1;
    chk(irq == 1'b1, "R10 collision irq", irq, 1);
    @(negedge clk); rd_collision = 1'b0; #0.1;
    chk(irq == 1'b0, "R10 collision gone", irq, 0);

    // full pass run with command-complete interrupt enabled
    wr(8'h80);
    fire(1'b1, 1'b0);
    chk(reg_rdata[5] == 1'b1 && cmd_done == 1'b0, "R5 request taken", {reg_rdata[5], cmd_done}, 2'b10);
    chk(arr_cmd == 4'b0001, "R5 erase strobe", arr_cmd, 4'b0001);
    chk(irq == 1'b0, "R10 irq low while busy", irq, 0);
    wr(8'h00);
    chk(reg_rdata == 8'h20, "R4 write while busy", reg_rdata, 8'h20);
    chk(arr_cmd == 4'b0001, "R6 erase held until done", arr_cmd, 4'b0001);
    wr(8'h80);
    fire(1'b0, 1'b0);
    wait_idle();
    chk(reg_rdata[5] == 1'b0 && cmd_done == 1'b1, "R7 request cleared", {reg_rdata[5], cmd_done}, 2'b01);
    chk(sec_open == 1'b1, "R7 security opened", sec_open, 1);
    chk(irq == 1'b1, "R10 irq on completion", irq, 1);
    repeat (20) @(negedge clk);
    chk(arr_cmd == 4'b0000 && cmd_done == 1'b1, "R9 no queued run", arr_cmd, 0);
    chk(exp_q.size() == 0, "R6 all strobes seen", exp_q.size(), 0);

    // aborted run
    do_reset();
    fail_verify = 1'b1;
    fire(1'b0, 1'b1);
    wait_idle();
    repeat (10) @(negedge clk);
    chk(sec_open == 1'b0, "R8 security kept", sec_open, 0);
    chk(reg_rdata[5] == 1'b0 && cmd_done == 1'b1, "R8 request cleared", {reg_rdata[5], cmd_done}, 2'b01);
    chk(exp_q.size() == 0, "R8 strobes seen", exp_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule